// File: doc/BRIEF.md
# Shared-Encoding Owner Selector

This block sits in a processor front end beside the decoders of several optional extension engines that all claim one shared instruction encoding. A writable pair of identity registers (a vendor identity and an architecture identity) says which engine owns that encoding. Software switches owners with a single register write. The enables only steer the decode, so no engine is reset, cleared or disabled by a switch, and an inner loop can alternate between engines cheaply.

The vendor identity is staged by its own write. The pair takes effect only when the architecture identity is written, and only if the staged vendor together with the new architecture value forms a supported pair. Any other pair is discarded and the registers keep their old contents, so a read always returns a supported pair. An accepted switch holds the decode stage for a fixed number of cycles. Each instruction word is matched against the shared encoding, and that match is ANDed with the one-hot owner select. This gives one enable per engine, or an illegal-instruction flag when the base pair owns the encoding. A build parameter makes the pair read-only for chips without custom engines.

Top module: `enc_owner_sel`

## Requirements
- R1: After a synchronous active-low reset, the pair reads back as the base pair (vendor 0x0000_0000, architecture 0x0000_0000), no engine enable is high and the stall request is low.
- R2: A write with `csr_sel`=0 stages a vendor value without changing the vendor readback. A write with `csr_sel`=1 commits the staged vendor and the written architecture together when they form a supported pair, and both readbacks show the new pair from the next cycle.
- R3: An architecture write whose pair is unsupported leaves both readbacks unchanged and starts no stall. Supported pairs are the base pair and vendor 0x0000_0A5C with architecture 0x100+k for engine k in 0..N_ENG-1.
- R4: While the pair for engine k is committed and no stall is active, a valid word matching the shared encoding (word AND 0x0000_707F equals 0x0000_200B) drives only `eng_en[k]` high in the same cycle.
- R5: At most one bit of `eng_en` is high in any cycle.
- R6: A word that does not match the shared encoding, or a cycle with `in_valid` low, raises no enable and no illegal flag.
- R7: While the base pair is committed and no stall is active, a valid matching word raises `illegal_instr` and no enable.
- R8: A committed switch raises the stall request for exactly the two cycles after the write. During those cycles no enable and no illegal flag is raised, and the word is held for the upstream stage to present again.
- R9: A new committed switch during a stall restarts the two-cycle stall from that write.
- R10: In the read-only build (WRITABLE=0) every write is ignored. The base pair is always read back and the stall request never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects vendor identity, 1 selects architecture identity (read and write) |
| csr_wdata | input | ID_W | Write data |
| csr_rdata | output | ID_W | Committed value of the selected identity register |
| in_valid | input | 1 | Instruction word valid |
| in_word | input | 32 | Instruction word |
| eng_en | output | N_ENG | Per-engine decode enable for the shared encoding |
| stall_req | output | 1 | Hold request while a switch takes effect |
| illegal_instr | output | 1 | Shared encoding seen with no owner selected |

## Verification
The switch and the decode meet when an architecture write and a valid shared-encoding word arrive in the same cycle. In that cycle the word must still be decoded under the old owner, and the stall starts only in the cycle after. The random phase sends writes and matching words together often. Back-to-back commits provoke the collision of a restart with a running stall. A bench model keeps the committed pair, the staged vendor and the stall count. It predicts the enables, the flag, the readback and the stall for every cycle, and it judges them before the next clock edge.

// File: rtl/enc_owner_sel_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the encoding owner selector.
package enc_owner_sel_pkg;

    // Instruction word width seen by the front end.
    localparam int INSN_W = 32;

    // Which identity register a register access addresses.
    typedef enum logic {
        ID_VENDOR = 1'b0,
        ID_ARCH   = 1'b1
    } id_sel_e;

    // True when a word belongs to the shared encoding.
    function automatic logic is_shared(
        input logic [INSN_W-1:0] word,
        input logic [INSN_W-1:0] mask,
        input logic [INSN_W-1:0] value
    );
        return (word & mask) == value;
    endfunction

endpackage

// File: rtl/idsel_id_regs.sv
`timescale 1ns/1ps
// Identity register pair with legal-value filtering.
// Writable variant: a vendor write is staged. An architecture write commits
// {staged vendor, written arch} only when the pair is supported. Otherwise
// the committed pair is kept. Read-only variant: the pair is fixed to the
// base values and commit never fires.
// Assumes BASE and EXT pairs are distinct and EXT_AID0+N_ENG-1 does not wrap.
module idsel_id_regs
    import enc_owner_sel_pkg::*;
#(
    parameter int            ID_W     = 32,
    parameter int            N_ENG    = 3,
    parameter bit            WRITABLE = 1'b1,
    parameter logic [ID_W-1:0] BASE_VID = '0,
    parameter logic [ID_W-1:0] BASE_AID = '0,
    parameter logic [ID_W-1:0] EXT_VID  = ID_W'(32'h0000_0A5C),
    parameter logic [ID_W-1:0] EXT_AID0 = ID_W'(32'h0000_0100)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [ID_W-1:0] wr_data,
    output logic [ID_W-1:0] cur_vid,
    output logic [ID_W-1:0] cur_aid,
    output logic            commit,
    output logic [N_ENG-1:0] owner_oh
);

    // One-hot owner decode from the committed pair.
    for (genvar k = 0; k < N_ENG; k++) begin : g_owner
        localparam logic [ID_W-1:0] AID_K = EXT_AID0 + ID_W'(k);
        assign owner_oh[k] = (cur_vid == EXT_VID) && (cur_aid == AID_K);
    end

    if (WRITABLE) begin : g_rw
        logic [ID_W-1:0] staged_vid;
        logic [ID_W-1:0] vid_q;
        logic [ID_W-1:0] aid_q;
        logic            ext_aid_hit;
        logic            pair_ok;

        // Does the written architecture value name one of the engines?
        always_comb begin
            ext_aid_hit = 1'b0;
            for (int k = 0; k < N_ENG; k++) begin
                if (wr_data == EXT_AID0 + ID_W'(k)) ext_aid_hit = 1'b1;
            end
        end

        // Legality of {staged vendor, written architecture}.
        assign pair_ok = ((staged_vid == BASE_VID) && (wr_data == BASE_AID)) ||
                         ((staged_vid == EXT_VID) && ext_aid_hit);

        assign commit = wr_en && (wr_sel == ID_ARCH) && pair_ok;

        // Stage vendor writes and commit legal pairs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                staged_vid <= BASE_VID;
                vid_q      <= BASE_VID;
                aid_q      <= BASE_AID;
            end else begin
                if (wr_en && (wr_sel == ID_VENDOR)) staged_vid <= wr_data;
                if (commit) begin
                    vid_q <= staged_vid;
                    aid_q <= wr_data;
                end
            end
        end

        assign cur_vid = vid_q;
        assign cur_aid = aid_q;
    end else begin : g_ro
        logic unused_wr;
        // Writes have no target in the fixed build.
        assign unused_wr = ^{wr_en, wr_sel, wr_data, clk, rst_n};
        assign cur_vid   = BASE_VID;
        assign cur_aid   = BASE_AID;
        assign commit    = 1'b0;
    end

endmodule

// File: rtl/idsel_stall_timer.sv
`timescale 1ns/1ps
// Switch stall timer: after a start pulse, busy is high for STALL_CYCLES
// cycles. A start while busy reloads the full count.
// Assumes STALL_CYCLES >= 1.
module idsel_stall_timer #(
    parameter int STALL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(STALL_CYCLES + 1);

    logic [CW-1:0] remain;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(STALL_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/idsel_route.sv
`timescale 1ns/1ps
// Decode-side gating: the shared-encoding match is ANDed with each engine's
// select bit. With no engine selected the word is flagged illegal. A hold
// suppresses every output so the word can be presented again.
// Assumes owner_oh is one-hot or zero.
module idsel_route
    import enc_owner_sel_pkg::*;
#(
    parameter int                N_ENG        = 3,
    parameter logic [INSN_W-1:0] SHARED_MASK  = 32'h0000_707F,
    parameter logic [INSN_W-1:0] SHARED_MATCH = 32'h0000_200B
) (
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_word,
    input  logic              hold,
    input  logic [N_ENG-1:0]  owner_oh,
    output logic [N_ENG-1:0]  eng_en,
    output logic              illegal
);

    logic live_hit;

    // Valid, not held, and in the shared encoding.
    assign live_hit = in_valid && !hold && is_shared(in_word, SHARED_MASK, SHARED_MATCH);

    // One extra AND input per engine.
    for (genvar k = 0; k < N_ENG; k++) begin : g_gate
        assign eng_en[k] = live_hit && owner_oh[k];
    end

    // No owner for the shared encoding.
    assign illegal = live_hit && (owner_oh == '0);

endmodule

// File: rtl/enc_owner_sel.sv
`timescale 1ns/1ps
// Top of the encoding owner selector: identity pair, switch stall and
// per-engine decode gating. Engines and the rest of the pipeline are
// outside; they see only eng_en, stall_req and illegal_instr.
module enc_owner_sel
    import enc_owner_sel_pkg::*;
#(
    parameter int                ID_W         = 32,
    parameter int                N_ENG        = 3,
    parameter bit                WRITABLE     = 1'b1,
    parameter int                STALL_CYCLES = 2,
    parameter logic [ID_W-1:0]   BASE_VID     = '0,
    parameter logic [ID_W-1:0]   BASE_AID     = '0,
    parameter logic [ID_W-1:0]   EXT_VID      = ID_W'(32'h0000_0A5C),
    parameter logic [ID_W-1:0]   EXT_AID0     = ID_W'(32'h0000_0100),
    parameter logic [INSN_W-1:0] SHARED_MASK  = 32'h0000_707F,
    parameter logic [INSN_W-1:0] SHARED_MATCH = 32'h0000_200B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic [ID_W-1:0]   csr_wdata,
    output logic [ID_W-1:0]   csr_rdata,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_word,
    output logic [N_ENG-1:0]  eng_en,
    output logic              stall_req,
    output logic              illegal_instr
);

    logic [ID_W-1:0]  cur_vid;
    logic [ID_W-1:0]  cur_aid;
    logic             wr_commit;
    logic [N_ENG-1:0] owner_oh;

    idsel_id_regs #(
        .ID_W(ID_W), .N_ENG(N_ENG), .WRITABLE(WRITABLE),
        .BASE_VID(BASE_VID), .BASE_AID(BASE_AID),
        .EXT_VID(EXT_VID), .EXT_AID0(EXT_AID0)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(csr_we), .wr_sel(csr_sel), .wr_data(csr_wdata),
        .cur_vid(cur_vid), .cur_aid(cur_aid),
        .commit(wr_commit), .owner_oh(owner_oh)
    );

    idsel_stall_timer #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
        .clk(clk), .rst_n(rst_n), .start(wr_commit), .busy(stall_req)
    );

    idsel_route #(
        .N_ENG(N_ENG), .SHARED_MASK(SHARED_MASK), .SHARED_MATCH(SHARED_MATCH)
    ) u_route (
        .in_valid(in_valid), .in_word(in_word), .hold(stall_req),
        .owner_oh(owner_oh), .eng_en(eng_en), .illegal(illegal_instr)
    );

    // Readback of the committed register chosen by csr_sel.
    assign csr_rdata = (csr_sel == ID_ARCH) ? cur_aid : cur_vid;

endmodule

// File: rtl/enc_owner_sel_chk.sv
`timescale 1ns/1ps
// Property checker for enc_owner_sel, bound into every instance.
module enc_owner_sel_chk #(
    parameter int ID_W     = 32,
    parameter int N_ENG    = 3,
    parameter bit WRITABLE = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [N_ENG-1:0] eng_en,
    input logic             stall_req,
    input logic             illegal_instr,
    input logic             commit,
    input logic [ID_W-1:0]  cur_vid,
    input logic [ID_W-1:0]  cur_aid,
    input logic [N_ENG-1:0] owner_oh
);

    a_r5_onehot_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_en));

    a_r4_enable_is_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_en != '0) |-> (eng_en == owner_oh));

    a_r8_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> ((eng_en == '0) && !illegal_instr));

    a_r8_stall_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> stall_req);

    a_r3_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(cur_vid) && $stable(cur_aid)));

    a_r7_illegal_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> (owner_oh == '0));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ((eng_en == '0) && !illegal_instr));

    a_r10_fixed_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITABLE == 1'b0) |-> !stall_req);

endmodule

bind enc_owner_sel enc_owner_sel_chk #(
    .ID_W(ID_W), .N_ENG(N_ENG), .WRITABLE(WRITABLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .eng_en(eng_en),
    .stall_req(stall_req), .illegal_instr(illegal_instr),
    .commit(wr_commit), .cur_vid(cur_vid), .cur_aid(cur_aid),
    .owner_oh(owner_oh)
);

// File: tb/sim_enc_owner_sel.sv
`timescale 1ns/1ps
module sim_enc_owner_sel;

    localparam int          NE    = 3;
    localparam logic [31:0] BVID  = 32'h0000_0000;
    localparam logic [31:0] BAID  = 32'h0000_0000;
    localparam logic [31:0] XVID  = 32'h0000_0A5C;
    localparam logic [31:0] XAID0 = 32'h0000_0100;
    localparam logic [31:0] MASK  = 32'h0000_707F;
    localparam logic [31:0] MATCH = 32'h0000_200B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic sel = 1'b0;
    logic [31:0] wdata = '0;
    logic iv = 1'b0;
    logic [31:0] iw = '0;

    logic [31:0]   rdata, ro_rdata;
    logic [NE-1:0] en, ro_en;
    logic          stall, ro_stall, ill, ro_ill;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench model state
    logic [31:0] m_vid, m_aid, m_stg;
    int          m_cnt;

    always #5 clk = ~clk;

    enc_owner_sel #(.N_ENG(NE), .WRITABLE(1'b1), .BASE_VID(BVID), .BASE_AID(BAID),
        .EXT_VID(XVID), .EXT_AID0(XAID0), .SHARED_MASK(MASK), .SHARED_MATCH(MATCH)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_sel(sel), .csr_wdata(wdata),
        .csr_rdata(rdata), .in_valid(iv), .in_word(iw), .eng_en(en),
        .stall_req(stall), .illegal_instr(ill));

    enc_owner_sel #(.N_ENG(NE), .WRITABLE(1'b0), .BASE_VID(BVID), .BASE_AID(BAID),
        .EXT_VID(XVID), .EXT_AID0(XAID0), .SHARED_MASK(MASK), .SHARED_MATCH(MATCH)) u_ro (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_sel(sel), .csr_wdata(wdata),
        .csr_rdata(ro_rdata), .in_valid(iv), .in_word(iw), .eng_en(ro_en),
        .stall_req(ro_stall), .illegal_instr(ro_ill));

    function automatic int owner_of(input logic [31:0] v, input logic [31:0] a);
        if (v == XVID && a >= XAID0 && a < XAID0 + NE) return int'(a - XAID0);
        return -1;
    endfunction

    function automatic bit legal_pair(input logic [31:0] v, input logic [31:0] a);
        return (v == BVID && a == BAID) || (owner_of(v, a) >= 0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One cycle: drive at negedge, judge before the next posedge, advance model.
    task automatic cycle(input logic we_i, input logic sel_i, input logic [31:0] wd,
                         input logic iv_i, input logic [31:0] iw_i);
        bit          match, st_e, ill_e, cm;
        int          own;
        logic [31:0] en_e, rd_e;
        @(negedge clk);
        we = we_i; sel = sel_i; wdata = wd; iv = iv_i; iw = iw_i;
        #1;
        match = ((iw_i & MASK) == MATCH);
        own   = owner_of(m_vid, m_aid);
        st_e  = (m_cnt != 0);
        en_e  = (iv_i && match && !st_e && own >= 0) ? (32'd1 << own) : 32'd0;
        ill_e = iv_i && match && !st_e && own < 0;
        rd_e  = sel_i ? m_aid : m_vid;
        chk(rdata == rd_e, "R2", "readback", rdata, rd_e);
        chk(32'(en) == en_e, "R4", "eng_en", 32'(en), en_e);
        chk(ill == ill_e, "R7", "illegal", 32'(ill), 32'(ill_e));
        chk(stall == st_e, "R8", "stall", 32'(stall), 32'(st_e));
        chk($countones(en) <= 1, "R5", "onehot", 32'(en), 32'd0);
        if (!iv_i || !match)
            chk(en == '0 && !ill, "R6", "no-match quiet", {31'd0, ill} | 32'(en), 32'd0);
        chk(ro_rdata == (sel_i ? BAID : BVID), "R10", "ro readback", ro_rdata, sel_i ? BAID : BVID);
        chk(!ro_stall && ro_en == '0 && ro_ill == (iv_i && match), "R10", "ro decode",
            {30'd0, ro_stall, ro_ill} | 32'(ro_en), {31'd0, iv_i && match});
        // model update for the coming edge
        cm = we_i && sel_i && legal_pair(m_stg, wd);
        if (cm) begin
            m_vid = m_stg; m_aid = wd; m_cnt = 2;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        if (we_i && !sel_i) m_stg = wd;
    endtask

    function automatic logic [31:0] shared_word();
        return ($urandom & ~MASK) | MATCH;
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_vid = BVID; m_aid = BAID; m_stg = BVID; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1;
        chk(rdata == BVID && stall == 1'b0 && en == '0, "R1", "reset state",
            rdata | {31'd0, stall}, BVID);
        cycle(0, 1, 0, 0, 0);
        chk(rdata == BAID, "R1", "reset arch", rdata, BAID);

        // R7: base owns the shared encoding
        cycle(0, 0, 0, 1, MATCH);
        chk(ill == 1'b1, "R7", "base flags illegal", 32'(ill), 32'd1);

        // R2: staged vendor not visible until commit
        cycle(1, 0, XVID, 0, 0);
        cycle(0, 0, 0, 0, 0);
        chk(rdata == BVID, "R2", "vendor staged only", rdata, BVID);
        // commit engine 1 with a shared word in the same cycle (old owner)
        cycle(1, 1, XAID0 + 1, 1, MATCH);
        // R8: two stalled cycles then engine 1 decodes
        cycle(0, 1, 0, 1, MATCH);
        chk(stall == 1'b1 && en == '0, "R8", "stall cycle 1", 32'(stall), 32'd1);
        cycle(0, 0, 0, 1, MATCH);
        chk(stall == 1'b1 && rdata == XVID, "R8", "stall cycle 2", 32'(stall), 32'd1);
        cycle(0, 1, 0, 1, MATCH | 32'hFF00_0000);
        chk(en == 3'b010 && !stall, "R4", "engine 1 owns", 32'(en), 32'd2);

        // R3: unsupported pair ignored, no stall
        cycle(1, 1, 32'h0000_0999, 0, 0);
        cycle(0, 1, 0, 1, MATCH);
        chk(rdata == XAID0 + 1 && !stall, "R3", "bad pair kept", rdata, XAID0 + 1);

        // R9: commit during stall restarts it
        cycle(1, 1, XAID0 + 2, 0, 0);
        cycle(0, 0, 0, 1, MATCH);
        cycle(1, 1, XAID0, 1, MATCH);
        cycle(0, 0, 0, 1, MATCH);
        chk(stall == 1'b1, "R9", "restart stall 1", 32'(stall), 32'd1);
        cycle(0, 0, 0, 1, MATCH);
        chk(stall == 1'b1, "R9", "restart stall 2", 32'(stall), 32'd1);
        cycle(0, 0, 0, 1, MATCH);
        chk(en == 3'b001, "R9", "engine 0 after restart", 32'(en), 32'd1);

        // R6: non-matching word
        cycle(0, 0, 0, 1, 32'h0000_0033);
        chk(en == '0 && !ill, "R6", "other encoding", 32'(en), 32'd0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] wd;
            logic [31:0] w;
            int pick = $urandom_range(0, 5);
            case (pick)
                0: wd = BVID;
                1: wd = XVID;
                2: wd = XAID0 + 32'($urandom_range(0, NE));
                3: wd = BAID;
                4: wd = XAID0 + 32'($urandom_range(0, NE - 1));
                default: wd = $urandom;
            endcase
            w = ($urandom_range(0, 1) == 1) ? shared_word() : $urandom;
            cycle($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, wd,
                  $urandom_range(0, 3) != 0, w);
        end

        summary();
    end

endmodule